// File: doc/BRIEF.md
# Hot-plug slot register controller

This block holds the slot control and slot status registers of a downstream port that supports hot-plug, and decides when the port signals an interrupt about slot events. Software reaches it through a small register port. The port has a register select, write data, two byte enables and a combinational read path. A third register holds the interrupt vector number. The slot side drives single-cycle event inputs: an attention button press, a card insertion request and a card removal request.

The status register records each event in a write-one-to-clear bit. A notify condition is formed from the hot-plug interrupt enable and from the event bits that their own enables allow. A two-state machine follows that condition and reports only its changes. The states are QUIET (condition last seen false) and ACTIVE (condition last seen true). There are three transitions:
- *raise*: QUIET to ACTIVE when the condition becomes true.
- *lower*: ACTIVE to QUIET when the condition becomes false for any reason other than a status clear.
- *silent drop*: ACTIVE to QUIET when the condition falls in the cycle right after a status write.

*raise* and *lower* fire a notification. With messages enabled, a notification is a one-cycle pulse that carries the vector. With messages disabled, the level output shows ACTIVE.

Every write that reaches the control register is one command, and it immediately raises the command-completed event. The write-one interlock control bit flips the interlock status bit and always reads back as zero. A card request made while the interlock is engaged is refused and reported through a busy pulse.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After reset, control reads 0x03C0, and both indicator fields hold the off code 2'b11. Status reads 0x0000 and the vector reads 0. `irq_level`, `msg_pulse` and `hp_busy` are all 0.
- R2: The notify condition is control bit 5 (interrupt enable) AND a non-zero result from status[4,3,0] ANDed with control[4,3,0]. With `msg_en` low, `irq_level` equals this condition one clock later.
- R3: With `msg_en` high, each *raise* or *lower* transition gives exactly one cycle of `msg_pulse`, with `msg_vec` equal to the vector register. `irq_level` stays 0.
- R4: When the notify condition keeps its value, there is no pulse and no level change. This includes raising an event bit that is already set.
- R5: Any write to control (select 0) with at least one byte enabled is one command, and it sets status bit 4 (command completed) at the same clock edge.
- R6: Writing 1 to control bit 11 with byte enable 1 inverts status bit 7 (interlock). Control bit 11 always reads 0.
- R7: A status write (select 1) clears those of bits 4, 3 and 0 that are written as 1. Bits 6 and 7 are not affected. If the condition falls in the next cycle, `irq_level` drops and no message is sent.
- R8: An event input in the same cycle as a status write is applied after the clear, so the event is not lost.
- R9: An insertion sets status bit 6 (presence) and bit 3 (presence changed). A removal clears bit 6 and sets bit 3.
- R10: An insertion or removal while status bit 7 is set pulses `hp_busy` for one cycle and leaves the status unchanged.
- R11: Only the enabled bytes of a write change state. A write with both byte enables low changes nothing and is not a command.
- R12: The vector register (select 2) holds 5 bits in byte 0 and reads back zero-extended.
- R13: An attention button press sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 vector |
| reg_wdata | input | 16 | Write data |
| reg_be | input | 2 | Byte enables |
| reg_rdata | output | 16 | Read data of the selected register |
| ev_button | input | 1 | Attention button press |
| ev_insert | input | 1 | Card insertion request |
| ev_remove | input | 1 | Card removal request |
| msg_en | input | 1 | Message-signalled interrupts enabled |
| irq_level | output | 1 | Level interrupt |
| msg_pulse | output | 1 | One-cycle interrupt message |
| msg_vec | output | 5 | Vector sent with the message |
| hp_busy | output | 1 | Refused request while interlocked |

## Verification
The assertions check the following relations on every cycle:
- a command is always followed by a set command-completed bit;
- the interlock toggle always flips the interlock status;
- presence never moves while the interlock is engaged;
- a message never appears without a state change or with messages disabled;
- the level output never leads the condition.

Only the bench scenarios can show the rest:
- the vector travelling with the pulse;
- the silent drop after a status clear, compared with the *lower* transition caused by a command;
- byte-enable masking;
- the zero read-back of the toggle bit;
- clear-versus-event ordering in the same cycle.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
    localparam int REG_W = 16;
    localparam int SEL_W = 2;
    localparam int NBYTE = REG_W / 8;

    localparam int C_AB_EN    = 0;
    localparam int C_PDC_EN   = 3;
    localparam int C_CC_EN    = 4;
    localparam int C_HP_IE    = 5;
    localparam int C_ATTN_LO  = 6;
    localparam int C_PWR_LO   = 8;
    localparam int C_LOCK_TGL = 11;

    localparam int S_AB   = 0;
    localparam int S_PDC  = 3;
    localparam int S_CC   = 4;
    localparam int S_PDS  = 6;
    localparam int S_LOCK = 7;

    localparam logic [1:0] IND_OFF = 2'b11;

    localparam logic [REG_W-1:0] EVT_MASK =
        (REG_W'(1) << S_AB) | (REG_W'(1) << S_PDC) | (REG_W'(1) << S_CC);
    localparam logic [REG_W-1:0] CTRL_WMASK =
        EVT_MASK | (REG_W'(1) << C_HP_IE) | (REG_W'(3) << C_ATTN_LO) | (REG_W'(3) << C_PWR_LO);
    localparam logic [REG_W-1:0] CTRL_RST =
        (REG_W'(IND_OFF) << C_ATTN_LO) | (REG_W'(IND_OFF) << C_PWR_LO);

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_VEC  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic {
        NS_QUIET  = 1'b0,
        NS_ACTIVE = 1'b1
    } ntf_state_e;
endpackage

// File: rtl/hp_slot_ctrl_reg.sv
module hp_slot_ctrl_reg
    import hp_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [REG_W-1:0] wdata,
    input  logic [NBYTE-1:0] wbe,
    output logic [REG_W-1:0] ctrl_q,
    output logic             cmd_done,
    output logic             lock_toggle
);
    logic [REG_W-1:0] bmask;
    logic [REG_W-1:0] wmask;

    for (genvar g = 0; g < NBYTE; g++) begin : g_lane
        assign bmask[8*g +: 8] = {8{wbe[g]}};
    end

    assign wmask       = bmask & CTRL_WMASK;
    assign cmd_done    = wr_hit && (|wbe);
    assign lock_toggle = wr_hit && bmask[C_LOCK_TGL] && wdata[C_LOCK_TGL];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RST;
        end else if (cmd_done) begin
            ctrl_q <= (ctrl_q & ~wmask) | (wdata & wmask);
        end
    end

    AST_LOCK_BIT_NEVER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        lock_toggle |=> !ctrl_q[C_LOCK_TGL]); // R6
endmodule

// File: rtl/hp_slot_status_reg.sv
module hp_slot_status_reg
    import hp_slot_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [REG_W-1:0] wdata,
    input  logic [NBYTE-1:0] wbe,
    input  logic             cmd_done,
    input  logic             lock_toggle,
    input  logic             ev_button,
    input  logic             ev_insert,
    input  logic             ev_remove,
    output logic [REG_W-1:0] sts_q,
    output logic             sts_wr_q,
    output logic             busy_q
);
    logic [REG_W-1:0] bmask;
    logic [REG_W-1:0] clr_bits;
    logic [REG_W-1:0] set_bits;
    logic [REG_W-1:0] sts_d;
    logic             locked;
    logic             take_ins;
    logic             take_rem;
    logic             pres_d;

    for (genvar g = 0; g < NBYTE; g++) begin : g_lane
        assign bmask[8*g +: 8] = {8{wbe[g]}};
    end

    assign locked   = sts_q[S_LOCK];
    assign take_ins = ev_insert && !locked;
    assign take_rem = ev_remove && !locked;
    assign clr_bits = wr_hit ? (wdata & bmask & EVT_MASK) : '0;

    always_comb begin
        set_bits        = '0;
        set_bits[S_AB]  = ev_button;
        set_bits[S_PDC] = take_ins || take_rem;
        set_bits[S_CC]  = cmd_done;
        if (take_ins) begin
            pres_d = 1'b1;
        end else if (take_rem) begin
            pres_d = 1'b0;
        end else begin
            pres_d = sts_q[S_PDS];
        end
        sts_d         = ((sts_q & EVT_MASK) & ~clr_bits) | set_bits;
        sts_d[S_PDS]  = pres_d;
        sts_d[S_LOCK] = locked ^ lock_toggle;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q    <= '0;
            sts_wr_q <= 1'b0;
            busy_q   <= 1'b0;
        end else begin
            sts_q    <= sts_d;
            sts_wr_q <= wr_hit && (|wbe);
            busy_q   <= (ev_insert || ev_remove) && locked;
        end
    end

    AST_CMD_RAISES_CC: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> sts_q[S_CC]); // R5
    AST_TOGGLE_FLIPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        lock_toggle |=> (sts_q[S_LOCK] != $past(sts_q[S_LOCK]))); // R6
    AST_BUTTON_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        ev_button |=> sts_q[S_AB]); // R8
    AST_INSERT_SETS_PRESENCE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_insert && !locked) |=> (sts_q[S_PDS] && sts_q[S_PDC])); // R9
    AST_LOCKED_KEEPS_PRESENCE: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (sts_q[S_PDS] == $past(sts_q[S_PDS]))); // R10
    AST_BUSY_ONLY_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> $past(sts_q[S_LOCK])); // R10
endmodule

// File: rtl/hp_notify_fsm.sv
module hp_notify_fsm #(
    parameter int VEC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cond_i,
    input  logic             sts_wr_i,
    input  logic             msg_en_i,
    input  logic [VEC_W-1:0] vec_i,
    output logic             irq_level,
    output logic             msg_pulse,
    output logic [VEC_W-1:0] msg_vec
);
    import hp_slot_pkg::*;

    ntf_state_e       state_q;
    ntf_state_e       state_d;
    logic             fire;
    logic             msg_q;
    logic [VEC_W-1:0] vec_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= NS_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            NS_QUIET: begin
                if (cond_i) begin
                    state_d = NS_ACTIVE;
                    fire    = 1'b1;
                end
            end
            NS_ACTIVE: begin
                if (!cond_i) begin
                    state_d = NS_QUIET;
                    fire    = !sts_wr_i;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_q <= 1'b0;
            vec_q <= '0;
        end else begin
            msg_q <= fire && msg_en_i;
            if (fire) begin
                vec_q <= vec_i;
            end
        end
    end

    assign irq_level = (state_q == NS_ACTIVE) && !msg_en_i;
    assign msg_pulse = msg_q;
    assign msg_vec   = vec_q;

    AST_PULSE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(state_q) |-> !msg_q); // R4
    AST_PULSE_NEEDS_MSG_EN: assert property (@(posedge clk) disable iff (!rst_n)
        msg_q |-> $past(msg_en_i)); // R3
    AST_SILENT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_wr_i && state_q == NS_ACTIVE && !cond_i) |=> !msg_q); // R7
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl #(
    parameter int VEC_W = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [15:0] reg_wdata,
    input  logic [1:0]  reg_be,
    output logic [15:0] reg_rdata,
    input  logic        ev_button,
    input  logic        ev_insert,
    input  logic        ev_remove,
    input  logic        msg_en,
    output logic        irq_level,
    output logic        msg_pulse,
    output logic [VEC_W-1:0] msg_vec,
    output logic        hp_busy
);
    import hp_slot_pkg::*;

    logic [REG_W-1:0] ctrl_q;
    logic [REG_W-1:0] sts_q;
    logic [VEC_W-1:0] vec_q;
    logic             cmd_done;
    logic             lock_toggle;
    logic             sts_wr_q;
    logic             ctrl_hit;
    logic             stat_hit;
    logic             cond;

    assign ctrl_hit = reg_wr && (reg_sel == SEL_CTRL);
    assign stat_hit = reg_wr && (reg_sel == SEL_STAT);

    hp_slot_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_hit      (ctrl_hit),
        .wdata       (reg_wdata),
        .wbe         (reg_be),
        .ctrl_q      (ctrl_q),
        .cmd_done    (cmd_done),
        .lock_toggle (lock_toggle)
    );

    hp_slot_status_reg u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_hit      (stat_hit),
        .wdata       (reg_wdata),
        .wbe         (reg_be),
        .cmd_done    (cmd_done),
        .lock_toggle (lock_toggle),
        .ev_button   (ev_button),
        .ev_insert   (ev_insert),
        .ev_remove   (ev_remove),
        .sts_q       (sts_q),
        .sts_wr_q    (sts_wr_q),
        .busy_q      (hp_busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (reg_wr && reg_sel == SEL_VEC && reg_be[0]) begin
            vec_q <= reg_wdata[VEC_W-1:0];
        end
    end

    assign cond = ctrl_q[C_HP_IE] && (|(sts_q & ctrl_q & EVT_MASK));

    hp_notify_fsm #(.VEC_W(VEC_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond_i    (cond),
        .sts_wr_i  (sts_wr_q),
        .msg_en_i  (msg_en),
        .vec_i     (vec_q),
        .irq_level (irq_level),
        .msg_pulse (msg_pulse),
        .msg_vec   (msg_vec)
    );

    always_comb begin
        unique case (reg_sel)
            SEL_CTRL: reg_rdata = ctrl_q;
            SEL_STAT: reg_rdata = sts_q;
            SEL_VEC:  reg_rdata = {{(REG_W-VEC_W){1'b0}}, vec_q};
            default:  reg_rdata = '0;
        endcase
    end

    AST_IRQ_AFTER_COND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level |-> $past(cond)); // R2
endmodule

// File: tb/test_hp_slot_ctrl.sv
module test_hp_slot_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [1:0]  reg_be = 2'b00;
    logic [15:0] reg_rdata;
    logic        ev_button = 1'b0;
    logic        ev_insert = 1'b0;
    logic        ev_remove = 1'b0;
    logic        msg_en = 1'b0;
    logic        irq_level;
    logic        msg_pulse;
    logic [4:0]  msg_vec;
    logic        hp_busy;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hp_slot_ctrl i_hp_slot_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
        .ev_button(ev_button), .ev_insert(ev_insert), .ev_remove(ev_remove),
        .msg_en(msg_en), .irq_level(irq_level), .msg_pulse(msg_pulse),
        .msg_vec(msg_vec), .hp_busy(hp_busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_ev(input logic [1:0] sel, input logic [15:0] d, input logic [1:0] be,
                         input bit btn, input bit ins, input bit rem);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d; reg_be = be;
        ev_button = btn; ev_insert = ins; ev_remove = rem;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 2'b00;
        ev_button = 1'b0; ev_insert = 1'b0; ev_remove = 1'b0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d, input logic [1:0] be);
        wr_ev(sel, d, be, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic pulse_ev(input bit btn, input bit ins, input bit rem);
        @(negedge clk);
        ev_button = btn; ev_insert = ins; ev_remove = rem;
        @(negedge clk);
        ev_button = 1'b0; ev_insert = 1'b0; ev_remove = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] sel, input logic [15:0] exp, input string req);
        reg_sel = sel;
        #1;
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic clear_status();
        wr(2'd1, 16'h00FF, 2'b01);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk(2'd0, 16'h03C0, "R1 control");
        rd_chk(2'd1, 16'h0000, "R1 status");
        rd_chk(2'd2, 16'h0000, "R1 vector");
        chk(irq_level == 0 && msg_pulse == 0 && hp_busy == 0, "R1 outputs",
            {irq_level, msg_pulse, hp_busy}, 0);
    endtask

    task automatic t_vector();
        wr(2'd2, 16'h0035, 2'b01);
        rd_chk(2'd2, 16'h0015, "R12 vector write");
        wr(2'd2, 16'hFF0A, 2'b10);
        rd_chk(2'd2, 16'h0015, "R12 R11 masked byte");
    endtask

    task automatic t_level();
        msg_en = 1'b0;
        wr(2'd0, 16'h03F0, 2'b11);
        rd_chk(2'd0, 16'h03F0, "R5 control value");
        rd_chk(2'd1, 16'h0010, "R5 command completed");
        @(negedge clk);
        chk(irq_level == 1, "R2 level asserted", irq_level, 1);
        chk(msg_pulse == 0, "R2 no message", msg_pulse, 0);
        wr(2'd1, 16'h0010, 2'b01);
        rd_chk(2'd1, 16'h0000, "R7 w1c");
        @(negedge clk);
        chk(irq_level == 0, "R7 level dropped", irq_level, 0);
    endtask

    task automatic t_msg();
        msg_en = 1'b1;
        wr(2'd0, 16'h03F0, 2'b11);
        @(negedge clk);
        chk(msg_pulse == 1, "R3 rise pulse", msg_pulse, 1);
        chk(msg_vec == 5'h15, "R3 vector", msg_vec, 5'h15);
        chk(irq_level == 0, "R3 level quiet", irq_level, 0);
        @(negedge clk);
        chk(msg_pulse == 0, "R3 single cycle", msg_pulse, 0);
        wr(2'd0, 16'h03F0, 2'b11);
        rd_chk(2'd1, 16'h0010, "R4 status unchanged");
        chk(msg_pulse == 0, "R4 no pulse a", msg_pulse, 0);
        @(negedge clk);
        chk(msg_pulse == 0, "R4 no pulse b", msg_pulse, 0);
        wr(2'd1, 16'h0010, 2'b01);
        @(negedge clk);
        chk(msg_pulse == 0, "R7 silent drop", msg_pulse, 0);
        @(negedge clk);
        chk(msg_pulse == 0, "R7 silent drop later", msg_pulse, 0);
        wr(2'd0, 16'h03F0, 2'b11);
        @(negedge clk);
        @(negedge clk);
        wr(2'd0, 16'h03D0, 2'b11);
        @(negedge clk);
        chk(msg_pulse == 1, "R3 lower pulse", msg_pulse, 1);
        msg_en = 1'b0;
        clear_status();
    endtask

    task automatic t_lock();
        wr(2'd0, 16'h0B00, 2'b10);
        rd_chk(2'd0, 16'h03D0, "R6 toggle reads zero");
        rd_chk(2'd1, 16'h0090, "R6 lock set");
        wr(2'd0, 16'h0B00, 2'b10);
        rd_chk(2'd1, 16'h0010, "R6 lock cleared");
        wr(2'd1, 16'h00C0, 2'b01);
        rd_chk(2'd1, 16'h0010, "R7 read-only bits kept");
    endtask

    task automatic t_bytes();
        clear_status();
        wr(2'd0, 16'h0000, 2'b01);
        rd_chk(2'd0, 16'h0300, "R11 low byte only");
        rd_chk(2'd1, 16'h0010, "R5 byte-lane command");
        clear_status();
        wr(2'd0, 16'hFFFF, 2'b00);
        rd_chk(2'd0, 16'h0300, "R11 no lanes no change");
        rd_chk(2'd1, 16'h0000, "R11 no lanes no command");
    endtask

    task automatic t_presence();
        clear_status();
        pulse_ev(0, 1, 0);
        rd_chk(2'd1, 16'h0048, "R9 insertion");
        wr(2'd1, 16'h0008, 2'b01);
        rd_chk(2'd1, 16'h0040, "R9 presence held");
        pulse_ev(0, 0, 1);
        rd_chk(2'd1, 16'h0008, "R9 removal");
    endtask

    task automatic t_busy();
        clear_status();
        wr(2'd0, 16'h0B00, 2'b10);
        pulse_ev(0, 1, 0);
        chk(hp_busy == 1, "R10 busy pulse", hp_busy, 1);
        rd_chk(2'd1, 16'h0090, "R10 status unchanged");
        @(negedge clk);
        chk(hp_busy == 0, "R10 busy one cycle", hp_busy, 0);
        wr(2'd0, 16'h0B00, 2'b10);
        rd_chk(2'd1, 16'h0010, "R10 unlocked no presence");
    endtask

    task automatic t_same_cycle();
        clear_status();
        pulse_ev(0, 1, 0);
        wr_ev(2'd1, 16'h0008, 2'b01, 1, 0, 0);
        rd_chk(2'd1, 16'h0041, "R13 R8 button during clear");
        wr_ev(2'd1, 16'h0008, 2'b01, 0, 0, 1);
        rd_chk(2'd1, 16'h0009, "R8 removal during clear");
    endtask

    task automatic t_level_pdc();
        msg_en = 1'b0;
        clear_status();
        wr(2'd0, 16'h0328, 2'b11);
        @(negedge clk);
        chk(irq_level == 0, "R2 disabled event masked", irq_level, 0);
        pulse_ev(0, 1, 0);
        @(negedge clk);
        chk(irq_level == 1, "R2 presence enabled", irq_level, 1);
        wr(2'd1, 16'h0008, 2'b01);
        @(negedge clk);
        chk(irq_level == 0, "R7 level cleared", irq_level, 0);
        pulse_ev(1, 0, 0);
        @(negedge clk);
        chk(irq_level == 0, "R2 button not enabled", irq_level, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_vector();
        t_level();
        t_msg();
        t_lock();
        t_bytes();
        t_presence();
        t_busy();
        t_same_cycle();
        t_level_pdc();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule